// File: doc/BRIEF.md
# Conference Sum-Minus-Self Mixer

This block is the arithmetic core of a time-multiplexed audio conference bridge. A frame carries up to 64 channel slots. For each slot, the upstream logic presents the slot's channel index, its 14-bit linear sample and that channel's connection settings: a conference number, a phase-invert flag and a start flag. The mixer keeps one stored sample per channel and one running sum per conference.

For a channel that belongs to a conference, the new sample replaces the one the channel contributed in the previous frame. The new sample is added and the stored one is subtracted. The block then returns the conference sum minus the channel's own new sample, so each party hears everyone else but not itself. Sums saturate instead of wrapping, and each saturation sets a sticky per-conference overflow flag. Software reads these flags in banks of eight.

Conference codes 1 to 29 select a conference. Code 0 means disconnected, 30 means tone and 31 means transparent. Each accepted slot walks a fixed state sequence:

- IDLE: wait for `slot_go`.
- LOAD: fetch the stored sample and the conference sum, and apply the phase flag.
- ADD: add the new sample.
- SUB: subtract the previous-frame sample, then write back both memories.
- OUT: form the result, then return to IDLE.

Top module: `cmx_mixer`

## Requirements
- R1: After reset, `out_valid` is 0, all overflow flags read 0, and every conference sum and stored channel sample is zero.
- R2: `slot_go` is accepted only in IDLE and is ignored in any other state. An accepted slot gives exactly one `out_valid` pulse, one cycle long, on the fourth rising edge after the accepting edge.
- R3: For a channel with code 1..29, `out_data` equals the sum of the latest effective samples of all other members of that conference, clamped to the range -8192..8191.
- R4: A channel's contribution to its conference is replaced every frame: the sample stored from the previous frame is subtracted when the new one is added.
- R5: When `slot_pt` is 1, the sample is negated before it enters the conference and before it is stored. An input of -8192 becomes 8191.
- R6: When `slot_start` is 1, the conference sum is treated as zero before this slot's addition.
- R7: Code 31 (transparent) outputs `slot_sample`. Code 30 (tone) outputs `tone_sample`. Code 0 outputs 0. None of these codes changes any conference sum, and all of them set the channel's stored sample to 0.
- R8: The conference sum saturates at 262143 and -262144 (19-bit signed) on both the add and the subtract step. Any saturation sets that conference's sticky flag. `out_ovf` shows the slot's conference flag alongside `out_valid`, and is 0 for codes 0, 30 and 31.
- R9: `ovf_bits` bit i shows the flag of conference `ovf_bank`*8+i. Pulsing `ovf_rd` clears the flags of the selected bank. A flag that is set in the same cycle stays set.
- R10: `out_ch` returns the channel index of the slot whose result is on `out_data`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| slot_go | input | 1 | Start processing the presented slot |
| slot_ch | input | 6 | Channel index of the slot |
| slot_sample | input | 14 | Linear sample, signed |
| slot_conf | input | 5 | Conference code: 0 off, 1..29 conference, 30 tone, 31 transparent |
| slot_pt | input | 1 | Phase-invert the sample |
| slot_start | input | 1 | Clear the conference sum before adding |
| tone_sample | input | 14 | Tone source sample for tone channels |
| out_valid | output | 1 | Result valid for one cycle |
| out_ch | output | 6 | Channel of the result |
| out_data | output | 14 | Result sample, signed |
| out_ovf | output | 1 | Slot's conference is flagged in overflow |
| ovf_bank | input | 2 | Bank of eight conferences to show |
| ovf_rd | input | 1 | Clear the flags of the shown bank |
| ovf_bits | output | 8 | Overflow flags of the selected bank |

## Verification
Four frames cover all 64 channels with a fixed mixture of codes:

- Several multi-member conferences, some members phase-inverted.
- Tone, transparent and disconnected slots interleaved among them.

The bench runs a pseudo-random sample sweep followed by a frame of alternating full-scale extremes. This separates three behaviours: correct self-exclusion, correct replacement of the previous frame's contribution, and output clamping. One frame restarts a conference mid-run, which shows the start flag discarding the accumulated sum. An all-disconnected frame is followed by 33 full-scale members in one conference. This drives the sum into saturation and checks the sticky flag, the bank read and the clear. A second `slot_go` while busy must leave only one result.

// File: rtl/cmx_pkg.sv
package cmx_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_LOAD,
        ST_ADD,
        ST_SUB,
        ST_OUT
    } cmx_state_e;
endpackage

// File: rtl/cmx_satadd.sv
module cmx_satadd #(
    parameter int W = 19
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    input  logic         sub,
    output logic [W-1:0] y,
    output logic         clip
);
    logic [W:0] wide;

    always_comb begin
        if (sub) wide = {a[W-1], a} - {b[W-1], b};
        else     wide = {a[W-1], a} + {b[W-1], b};
        clip = wide[W] != wide[W-1];
        if (clip) y = wide[W] ? {1'b1, {(W-1){1'b0}}} : {1'b0, {(W-1){1'b1}}};
        else      y = wide[W-1:0];
    end
endmodule

// File: rtl/cmx_ovf_bank.sv
module cmx_ovf_bank #(
    parameter int NCONF = 32
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         set_en,
    input  logic [$clog2(NCONF)-1:0]     set_idx,
    input  logic                         rd,
    input  logic [$clog2(NCONF/8)-1:0]   bank,
    input  logic [$clog2(NCONF)-1:0]     look_idx,
    output logic [7:0]                   bits,
    output logic                         look_flag
);
    localparam int NBANK = NCONF / 8;

    logic [NCONF-1:0] flags;
    logic [NCONF-1:0] clr_mask, set_mask;

    always_comb begin
        clr_mask = '0;
        set_mask = '0;
        if (rd)     clr_mask[bank*8 +: 8] = 8'hFF;
        if (set_en) set_mask[set_idx] = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) flags <= '0;
        else        flags <= (flags & ~clr_mask) | set_mask;
    end

    assign bits      = flags[bank*8 +: 8];
    assign look_flag = flags[look_idx];

    // R8
    sticky_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        set_en |=> flags[$past(set_idx)]);

    for (genvar g = 0; g < NBANK; g++) begin : g_bank_chk
        // R9
        bank_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (rd && bank == g && !set_en) |=> (flags[g*8 +: 8] == 8'h00));
    end
endmodule

// File: rtl/cmx_mixer.sv
module cmx_mixer
    import cmx_pkg::*;
#(
    parameter int NCH    = 64,
    parameter int NCONF  = 32,
    parameter int SAMP_W = 14,
    parameter int ACC_W  = 19
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         slot_go,
    input  logic [$clog2(NCH)-1:0]       slot_ch,
    input  logic [SAMP_W-1:0]            slot_sample,
    input  logic [$clog2(NCONF)-1:0]     slot_conf,
    input  logic                         slot_pt,
    input  logic                         slot_start,
    input  logic [SAMP_W-1:0]            tone_sample,
    output logic                         out_valid,
    output logic [$clog2(NCH)-1:0]       out_ch,
    output logic [SAMP_W-1:0]            out_data,
    output logic                         out_ovf,
    input  logic [$clog2(NCONF/8)-1:0]   ovf_bank,
    input  logic                         ovf_rd,
    output logic [7:0]                   ovf_bits
);
    localparam int CH_W = $clog2(NCH);
    localparam int CF_W = $clog2(NCONF);
    localparam logic [CF_W-1:0] CODE_OFF   = '0;
    localparam logic [CF_W-1:0] CODE_TONE  = CF_W'(NCONF - 2);
    localparam logic [CF_W-1:0] CODE_TRANS = CF_W'(NCONF - 1);
    localparam logic [SAMP_W-1:0] S_MIN = {1'b1, {(SAMP_W-1){1'b0}}};
    localparam logic [SAMP_W-1:0] S_MAX = {1'b0, {(SAMP_W-1){1'b1}}};

    cmx_state_e state_q, state_d;

    logic [CH_W-1:0]   ch_q;
    logic [SAMP_W-1:0] x_q, tone_q, xe_q, prev_q;
    logic [CF_W-1:0]   conf_q;
    logic              pt_q, start_q, clip_q;
    logic [ACC_W-1:0]  acc_q;
    logic [SAMP_W-1:0] fmem [NCH];
    logic [ACC_W-1:0]  csum [NCONF];

    logic              is_mix;
    logic [ACC_W-1:0]  add_b, add_y;
    logic              add_clip, ovf_set, look_flag;
    logic [ACC_W:0]    others;
    logic [SAMP_W-1:0] others_clamped;

    assign is_mix = (conf_q != CODE_OFF) && (conf_q < CODE_TONE);

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // Next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (slot_go) state_d = ST_LOAD;
            ST_LOAD: state_d = ST_ADD;
            ST_ADD:  state_d = ST_SUB;
            ST_SUB:  state_d = ST_OUT;
            ST_OUT:  state_d = ST_IDLE;
            default: state_d = ST_IDLE;
        endcase
    end

    // Shared saturating adder: ADD adds the new sample, SUB removes the old one
    assign add_b = (state_q == ST_SUB) ? ACC_W'($signed(prev_q)) : ACC_W'($signed(xe_q));

    cmx_satadd #(.W(ACC_W)) u_add (
        .a    (acc_q),
        .b    (add_b),
        .sub  (state_q == ST_SUB),
        .y    (add_y),
        .clip (add_clip)
    );

    assign ovf_set = (state_q == ST_SUB) && is_mix && (clip_q || add_clip);

    cmx_ovf_bank #(.NCONF(NCONF)) u_ovf (
        .clk       (clk),
        .rst_n     (rst_n),
        .set_en    (ovf_set),
        .set_idx   (conf_q),
        .rd        (ovf_rd),
        .bank      (ovf_bank),
        .look_idx  (conf_q),
        .bits      (ovf_bits),
        .look_flag (look_flag)
    );

    // Everyone else in the conference, clamped to the sample range
    always_comb begin
        others = {acc_q[ACC_W-1], acc_q} - (ACC_W+1)'($signed(xe_q));
        if ($signed(others) > $signed((ACC_W+1)'($signed(S_MAX))))      others_clamped = S_MAX;
        else if ($signed(others) < $signed((ACC_W+1)'($signed(S_MIN)))) others_clamped = S_MIN;
        else                                                            others_clamped = others[SAMP_W-1:0];
    end

    // Datapath registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ch_q    <= '0;
            x_q     <= '0;
            tone_q  <= '0;
            conf_q  <= '0;
            pt_q    <= 1'b0;
            start_q <= 1'b0;
            xe_q    <= '0;
            prev_q  <= '0;
            acc_q   <= '0;
            clip_q  <= 1'b0;
        end else begin
            unique case (state_q)
                ST_IDLE: if (slot_go) begin
                    ch_q    <= slot_ch;
                    x_q     <= slot_sample;
                    tone_q  <= tone_sample;
                    conf_q  <= slot_conf;
                    pt_q    <= slot_pt;
                    start_q <= slot_start;
                end
                ST_LOAD: begin
                    if (pt_q) xe_q <= (x_q == S_MIN) ? S_MAX : -x_q;
                    else      xe_q <= x_q;
                    prev_q <= fmem[ch_q];
                    acc_q  <= start_q ? '0 : csum[conf_q];
                end
                ST_ADD: begin
                    acc_q  <= add_y;
                    clip_q <= add_clip;
                end
                ST_SUB:  acc_q <= add_y;
                ST_OUT:  ;
                default: ;
            endcase
        end
    end

    // Frame memory and conference sums, written back in SUB
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < NCH; i++)   fmem[i] <= '0;
            for (int i = 0; i < NCONF; i++) csum[i] <= '0;
        end else if (state_q == ST_SUB) begin
            fmem[ch_q] <= is_mix ? xe_q : '0;
            if (is_mix) csum[conf_q] <= add_y;
        end
    end

    // Output process
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            out_ch    <= '0;
            out_data  <= '0;
            out_ovf   <= 1'b0;
        end else if (state_q == ST_OUT) begin
            out_valid <= 1'b1;
            out_ch    <= ch_q;
            out_ovf   <= is_mix && look_flag;
            if (is_mix)                    out_data <= others_clamped;
            else if (conf_q == CODE_TRANS) out_data <= x_q;
            else if (conf_q == CODE_TONE)  out_data <= tone_q;
            else                           out_data <= '0;
        end else begin
            out_valid <= 1'b0;
        end
    end

    // R2
    single_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |=> !out_valid);

    // R2
    busy_ignore_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (slot_go && state_q != ST_IDLE) |=> state_q != ST_LOAD);

    // R2
    phase_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_ADD) |=> (state_q == ST_SUB));

    // R2
    valid_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(out_valid) |-> $past(state_q) == ST_OUT);

    // R8
    no_ovf_on_bypass_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !is_mix) |-> !out_ovf);
endmodule

// File: tb/cmx_mixer_tb.sv
module cmx_mixer_tb;
    localparam int CLK_PERIOD = 10;
    localparam int MAXA = 262143;
    localparam int MINA = -262144;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       slot_go = 1'b0;
    logic [5:0] slot_ch = '0;
    logic [13:0] slot_sample = '0;
    logic [4:0] slot_conf = '0;
    logic       slot_pt = 1'b0;
    logic       slot_start = 1'b0;
    logic [13:0] tone_sample = '0;
    logic       out_valid;
    logic [5:0] out_ch;
    logic [13:0] out_data;
    logic       out_ovf;
    logic [1:0] ovf_bank = '0;
    logic       ovf_rd = 1'b0;
    logic [7:0] ovf_bits;

    int n_checks = 0;
    int n_fail = 0;
    bit done = 0;

    int  mprev [64];
    int  msum  [32];
    bit  mflag [32];
    bit  started [32];

    always #(CLK_PERIOD/2) clk = ~clk;

    cmx_mixer u_dut (
        .clk(clk), .rst_n(rst_n), .slot_go(slot_go), .slot_ch(slot_ch),
        .slot_sample(slot_sample), .slot_conf(slot_conf), .slot_pt(slot_pt),
        .slot_start(slot_start), .tone_sample(tone_sample), .out_valid(out_valid),
        .out_ch(out_ch), .out_data(out_data), .out_ovf(out_ovf),
        .ovf_bank(ovf_bank), .ovf_rd(ovf_rd), .ovf_bits(ovf_bits)
    );

    task automatic chk(bit ok, string req, int act, int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic int sat(int v, int conf);
        if (v > MAXA) begin mflag[conf] = 1; return MAXA; end
        if (v < MINA) begin mflag[conf] = 1; return MINA; end
        return v;
    endfunction

    task automatic run_slot(int ch, int x, int conf, bit pt, bit st, int tone, string req);
        int xe, s, e;
        bit eovf;
        if (conf >= 1 && conf <= 29) begin
            xe = pt ? ((x == -8192) ? 8191 : -x) : x;
            s = st ? 0 : msum[conf];
            s = sat(s + xe, conf);
            s = sat(s - mprev[ch], conf);
            msum[conf] = s;
            mprev[ch] = xe;
            e = s - xe;
            if (e > 8191) e = 8191;
            if (e < -8192) e = -8192;
            eovf = mflag[conf];
        end else begin
            mprev[ch] = 0;
            e = (conf == 31) ? x : (conf == 30) ? tone : 0;
            eovf = 0;
        end
        slot_go = 1; slot_ch = 6'(ch); slot_sample = 14'(x); slot_conf = 5'(conf);
        slot_pt = pt; slot_start = st; tone_sample = 14'(tone);
        @(negedge clk);
        slot_go = 0;
        repeat (3) @(negedge clk);
        chk(!out_valid, "R2", out_valid, 0);
        @(negedge clk);
        chk(out_valid, "R2", out_valid, 1);
        chk(int'($signed(out_data)) == e, req, int'($signed(out_data)), e);
        chk(out_ovf == eovf, "R8", out_ovf, eovf);
        chk(out_ch == 6'(ch), "R10", out_ch, ch);
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        if (!done) begin
            n_checks++; n_fail++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        int cnt;
        foreach (mprev[i]) mprev[i] = 0;
        foreach (msum[i]) begin msum[i] = 0; mflag[i] = 0; started[i] = 0; end
        repeat (3) @(negedge clk);
        // R1 reset state
        chk(!out_valid, "R1", out_valid, 0);
        for (int b = 0; b < 4; b++) begin
            ovf_bank = 2'(b);
            #1;
            chk(ovf_bits == 8'h00, "R1", ovf_bits, 0);
        end
        rst_n = 1;
        @(negedge clk);
        chk(!out_valid, "R1", out_valid, 0);

        // Sweep: four frames over all channels
        for (int f = 0; f < 4; f++) begin
            bit restarted = 0;
            for (int ch = 0; ch < 64; ch++) begin
                int conf, x;
                bit pt, st;
                string req;
                if (ch % 16 == 6)      conf = 30;
                else if (ch % 8 == 7)  conf = 31;
                else if (ch % 8 == 5)  conf = 0;
                else                   conf = (ch >= 32) ? 26 + (ch % 4) : 1 + (ch % 4);
                pt = (ch % 3 == 0);
                if (f == 3) x = (ch % 2) ? 8191 : -8192;
                else        x = ((ch * 1237 + f * 2903 + 77) % 16384) - 8192;
                st = 0;
                if (conf >= 1 && conf <= 29 && !started[conf]) begin st = 1; started[conf] = 1; end
                if (f == 2 && conf == 2 && !restarted) begin st = 1; restarted = 1; end
                if (conf == 0 || conf >= 30) req = "R7";
                else if (st)                 req = "R6";
                else if (pt)                 req = "R5";
                else if (f > 0)              req = "R4";
                else                         req = "R3";
                run_slot(ch, x, conf, pt, st, f * 100 - ch, req);
            end
        end

        // Disconnect frame: every output zero, stored samples cleared (R7)
        for (int ch = 0; ch < 64; ch++) run_slot(ch, 1000 + ch, 0, 0, 0, 0, "R7");

        // Overflow frame: 33 full-scale members of conference 9 (R8)
        for (int ch = 0; ch < 33; ch++) run_slot(ch, 8191, 9, 0, ch == 0, 0, "R8");

        // R9 bank read and clear
        ovf_bank = 2'd1;
        #1;
        chk(ovf_bits == 8'h02, "R9", ovf_bits, 2);
        ovf_bank = 2'd0;
        #1;
        chk(ovf_bits == 8'h00, "R9", ovf_bits, 0);
        ovf_bank = 2'd1;
        ovf_rd = 1;
        @(negedge clk);
        ovf_rd = 0;
        #1;
        chk(ovf_bits == 8'h00, "R9", ovf_bits, 0);
        mflag[9] = 0;

        // R2 second slot_go while busy is ignored
        slot_go = 1; slot_ch = 6'd40; slot_sample = 14'd777; slot_conf = 5'd31;
        slot_pt = 0; slot_start = 0;
        @(negedge clk);
        slot_ch = 6'd41; slot_sample = 14'd5; slot_conf = 5'd3; slot_start = 1;
        @(negedge clk);
        slot_go = 0;
        cnt = 0;
        for (int i = 0; i < 12; i++) begin
            @(negedge clk);
            if (out_valid) begin
                cnt++;
                chk(out_data == 14'd777, "R2", out_data, 777);
                chk(out_ch == 6'd40, "R10", out_ch, 40);
            end
        end
        chk(cnt == 1, "R2", cnt, 1);

        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    end
endmodule